// File: doc/BRIEF.md
# Trimmed Nanosecond Time-of-Day Counter

This block keeps a free-running time of day for packet timing. Time is held as a 40-bit count of whole nanoseconds with a 32-bit fraction of a nanosecond below it. On every clock the count moves forward by a fixed base step of 8 ns. A signed trim word then nudges the fraction up or down on each tick, so software can pull the clock rate fast or slow in steps of 2^-32 ns per tick. An offset of p parts per billion maps to a trim magnitude of p·2^26/1953125, and the trim reaches offsets up to about 62.5 million parts per billion.

Software reaches the counter through a small word-wide register bus. A multi-word read of the time is made coherent by a snapshot: reading the fraction word latches the whole nanosecond count, and the two nanosecond words then return that frozen copy. A multi-word write is made coherent in the other direction: the fraction and low words are staged, and writing the high word loads all 72 bits in a single cycle. A control word holds a halt bit that stops the counter, and the counter comes out of reset halted.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the nanosecond count, fraction, trim word and snapshot are all zero, and the control word at address 4 reads 0x8000_0000 (halted).
- R2: The counter advances only while bit 31 of the control word is clear. While it is set, neither count nor fraction changes. The control word reads back only bit 31, and its other bits read zero.
- R3: With a zero trim magnitude, each running clock adds exactly 8 to the nanosecond count and leaves the fraction unchanged.
- R4: With trim bit 31 clear, each running clock adds the magnitude in trim bits 30:0 to the fraction. A carry out of the fraction adds one more nanosecond to that clock's step of 8.
- R5: With trim bit 31 set, each running clock subtracts the magnitude from the fraction. A borrow removes one nanosecond from that clock's step of 8.
- R6: The nanosecond count wraps modulo 2^40.
- R7: Address 0 is the fraction, address 1 is nanoseconds 31:0, address 2 holds nanoseconds 39:32 in bits 7:0 with bits 31:8 reading zero, address 3 is the trim and address 4 is the control word. Read data and its valid flag appear on the clock after the read request.
- R8: A read of address 0 returns the live fraction and latches the live nanosecond count into the snapshot. Reads of addresses 1 and 2 return the snapshot. Nothing else changes the snapshot.
- R9: Writes to addresses 0 and 1 only stage data and leave the running time untouched. A write to address 2 loads the staged fraction, the staged low word and its own bits 7:0 as one update, and counting continues from the loaded value on the next clock.
- R10: The trim word reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time step per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |

## Verification
The hardest case to reach from the ports is a snapshot that must stay coherent while the count keeps moving underneath it, in particular when the low word rolls over into the high word between the latching read and the later word reads. The stimulus loads a count just below a low-word rollover, releases the halt, and latches the count a known number of clocks later. It then reads the two nanosecond words several clocks apart while the counter runs past the rollover. The trim cases start from fractions near the top and bottom of the range, so that a carry or borrow happens on a predictable tick, and they compare the result against a closed-form count of the ticks.

// File: rtl/ntk_pkg.sv
package ntk_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_FRAC = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_NSLO = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_NSHI = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TRIM = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd4;
endpackage

// File: rtl/ntk_frac_step.sv
module ntk_frac_step
    import ntk_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic [DATA_W-1:0] frac_q,
    input  logic              trim_neg,
    input  logic [DATA_W-2:0] trim_mag,
    output logic [DATA_W-1:0] frac_d,
    output logic [NS_W-1:0]   step_ns
);
    logic [DATA_W:0] wide;

    always_comb begin
        if (trim_neg)
            wide = {1'b0, frac_q} - {2'b00, trim_mag};
        else
            wide = {1'b0, frac_q} + {2'b00, trim_mag};
        frac_d = wide[DATA_W-1:0];
        // top bit is a carry when adding, a borrow when subtracting
        if (trim_neg)
            step_ns = NS_W'(STEP_NS) - NS_W'(wide[DATA_W]);
        else
            step_ns = NS_W'(STEP_NS) + NS_W'(wide[DATA_W]);
    end
endmodule

// File: rtl/ntk_regbank.sv
module ntk_regbank
    import ntk_pkg::*;
#(
    parameter int NS_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NS_W-1:0]   live_ns,
    input  logic [DATA_W-1:0] live_frac,
    output logic              trim_neg,
    output logic [DATA_W-2:0] trim_mag,
    output logic              halt,
    output logic              load_en,
    output logic [NS_W-1:0]   load_ns,
    output logic [DATA_W-1:0] load_frac
);
    localparam int HI_W = NS_W - DATA_W;

    typedef struct packed {
        logic [NS_W-1:0]   snap_ns;
        logic [DATA_W-1:0] stage_frac;
        logic [DATA_W-1:0] stage_lo;
        logic              trim_neg;
        logic [DATA_W-2:0] trim_mag;
        logic              halt;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } bank_t;

    bank_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = bus_rd;
        r_d.rdata  = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADR_FRAC: begin
                    r_d.rdata   = live_frac;
                    r_d.snap_ns = live_ns;
                end
                ADR_NSLO: r_d.rdata = r_q.snap_ns[DATA_W-1:0];
                ADR_NSHI: r_d.rdata = DATA_W'(r_q.snap_ns[NS_W-1:DATA_W]);
                ADR_TRIM: r_d.rdata = {r_q.trim_neg, r_q.trim_mag};
                ADR_CTRL: r_d.rdata = {r_q.halt, {(DATA_W-1){1'b0}}};
                default:  r_d.rdata = '0;
            endcase
        end
        if (bus_wr) begin
            case (bus_addr)
                ADR_FRAC: r_d.stage_frac = bus_wdata;
                ADR_NSLO: r_d.stage_lo   = bus_wdata;
                ADR_TRIM: begin
                    r_d.trim_neg = bus_wdata[DATA_W-1];
                    r_d.trim_mag = bus_wdata[DATA_W-2:0];
                end
                ADR_CTRL: r_d.halt = bus_wdata[DATA_W-1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.halt <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign trim_neg   = r_q.trim_neg;
    assign trim_mag   = r_q.trim_mag;
    assign halt       = r_q.halt;
    assign load_en    = bus_wr && (bus_addr == ADR_NSHI);
    assign load_ns    = {bus_wdata[HI_W-1:0], r_q.stage_lo};
    assign load_frac  = r_q.stage_frac;

    // R7: valid flag follows the read strobe by one clock
    a_r7_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R7: reserved upper bits of the high word read zero
    a_r7_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_NSHI) |=> (bus_rdata[DATA_W-1:HI_W] == '0));
    // R8: snapshot moves only on a fraction read
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADR_FRAC) |=> $stable(r_q.snap_ns));
    // R2: control read shows only the halt bit
    a_r2_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_CTRL) |=> (bus_rdata[DATA_W-2:0] == '0));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import ntk_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [DATA_W-1:0] frac;
    } tod_t;

    tod_t t_d, t_q;

    logic              trim_neg;
    logic [DATA_W-2:0] trim_mag;
    logic              halt;
    logic              load_en;
    logic [NS_W-1:0]   load_ns;
    logic [DATA_W-1:0] load_frac;
    logic [DATA_W-1:0] frac_next;
    logic [NS_W-1:0]   step_ns;

    ntk_regbank #(.NS_W(NS_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .live_ns    (t_q.ns),
        .live_frac  (t_q.frac),
        .trim_neg   (trim_neg),
        .trim_mag   (trim_mag),
        .halt       (halt),
        .load_en    (load_en),
        .load_ns    (load_ns),
        .load_frac  (load_frac)
    );

    ntk_frac_step #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_step (
        .frac_q   (t_q.frac),
        .trim_neg (trim_neg),
        .trim_mag (trim_mag),
        .frac_d   (frac_next),
        .step_ns  (step_ns)
    );

    always_comb begin
        t_d = t_q;
        if (load_en) begin
            t_d.ns   = load_ns;
            t_d.frac = load_frac;
        end else if (!halt) begin
            t_d.ns   = t_q.ns + step_ns;
            t_d.frac = frac_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R2: halted time holds still
    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load_en) |=> ($stable(t_q.ns) && $stable(t_q.frac)));
    // R3: untrimmed step is exactly the base step
    a_r3_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !load_en && trim_mag == '0) |=>
        ((t_q.ns - $past(t_q.ns)) == NS_W'(STEP_NS) && $stable(t_q.frac)));
    // R4: positive trim never shortens a step
    a_r4_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !load_en && !trim_neg) |=>
        ((t_q.ns - $past(t_q.ns)) == NS_W'(STEP_NS) ||
         (t_q.ns - $past(t_q.ns)) == NS_W'(STEP_NS + 1)));
    // R5: negative trim never lengthens a step
    a_r5_neg_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !load_en && trim_neg) |=>
        ((t_q.ns - $past(t_q.ns)) == NS_W'(STEP_NS) ||
         (t_q.ns - $past(t_q.ns)) == NS_W'(STEP_NS - 1)));
    // R9: a high-word write loads all fields in one clock
    a_r9_commit: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (t_q.ns == $past(load_ns) && t_q.frac == $past(load_frac)));
endmodule

// File: tb/ns_time_counter_bench.sv
`timescale 1ns/1ps
module ns_time_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ns_time_counter u_ns_time_counter (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R7 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    // all tasks are entered on a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_time(input logic [39:0] ns, input logic [31:0] fr);
        wr(3'd0, fr);
        wr(3'd1, ns[31:0]);
        wr(3'd2, {24'hA5C3E1, ns[39:32]});   // junk above bit 7
    endtask

    task automatic check_time(input logic [39:0] ns, input logic [31:0] fr, input string tag);
        rd(3'd0, fr, tag);
        rd(3'd1, ns[31:0], tag);
        rd(3'd2, {24'h0, ns[39:32]}, tag);
    endtask

    // exactly t running clocks
    task automatic run(input int t);
        wr(3'd4, 32'h0);
        repeat (t - 1) @(negedge clk);
        wr(3'd4, 32'h8000_0000);
    endtask

    function automatic logic [71:0] expect_after(input logic [39:0] ns, input logic [31:0] fr,
                                                 input logic [30:0] mag, input bit neg, input int t);
        longint acc;
        longint n;
        acc = neg ? (longint'(fr) - longint'(t) * longint'(mag))
                  : (longint'(fr) + longint'(t) * longint'(mag));
        n = longint'(ns) + 8 * longint'(t) + (acc >>> 32);
        return {n[39:0], acc[31:0]};
    endfunction

    logic [71:0] e;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd4, 32'h8000_0000, "R1 control after reset");
        rd(3'd3, 32'h0, "R1 trim after reset");
        rd(3'd1, 32'h0, "R1 snapshot low after reset");
        check_time(40'h0, 32'h0, "R1 time after reset");

        // R2: halted clock does not move; control keeps only bit 31
        repeat (10) @(negedge clk);
        check_time(40'h0, 32'h0, "R2 halted time holds");
        wr(3'd4, 32'h8000_FFFF);
        rd(3'd4, 32'h8000_0000, "R2 control reads only bit 31");

        // R9 / R7: load and field layout
        set_time(40'h12_3456_789A, 32'hDEAD_BEEF);
        check_time(40'h12_3456_789A, 32'hDEAD_BEEF, "R9 R7 loaded time");
        wr(3'd0, 32'h1111_1111);
        wr(3'd1, 32'h2222_2222);
        check_time(40'h12_3456_789A, 32'hDEAD_BEEF, "R9 staged words not applied");

        // R10: trim read back
        wr(3'd3, 32'h8000_1234);
        rd(3'd3, 32'h8000_1234, "R10 trim read back");

        // R3: untrimmed base step
        wr(3'd3, 32'h0);
        set_time(40'h00_0000_1000, 32'h0123_4567);
        run(20);
        e = expect_after(40'h00_0000_1000, 32'h0123_4567, 31'h0, 1'b0, 20);
        check_time(e[71:32], e[31:0], "R3 base step 20 clocks");

        // R4: positive trim with carries
        wr(3'd3, 32'h4000_0000);
        set_time(40'h00_0000_2000, 32'hE000_0000);
        run(10);
        e = expect_after(40'h00_0000_2000, 32'hE000_0000, 31'h4000_0000, 1'b0, 10);
        check_time(e[71:32], e[31:0], "R4 positive trim carries");

        // R4: largest magnitude
        wr(3'd3, 32'h7FFF_FFFF);
        set_time(40'h00_0000_3000, 32'h0000_0005);
        run(7);
        e = expect_after(40'h00_0000_3000, 32'h0000_0005, 31'h7FFF_FFFF, 1'b0, 7);
        check_time(e[71:32], e[31:0], "R4 full-scale trim");

        // R5: negative trim with borrows
        wr(3'd3, 32'hC000_0000);
        set_time(40'h00_0000_4000, 32'h2000_0000);
        run(5);
        e = expect_after(40'h00_0000_4000, 32'h2000_0000, 31'h4000_0000, 1'b1, 5);
        check_time(e[71:32], e[31:0], "R5 negative trim borrows");

        // R6: wrap of the 40-bit count
        wr(3'd3, 32'h0);
        set_time(40'hFF_FFFF_FFF0, 32'h0);
        run(5);
        check_time(40'h00_0000_0018, 32'h0, "R6 wrap modulo 2^40");

        // R8: snapshot held until the next fraction read
        set_time(40'h01_0000_0001, 32'h0000_00AA);
        rd(3'd0, 32'h0000_00AA, "R8 latch first value");
        set_time(40'h02_0000_0002, 32'h0000_00BB);
        rd(3'd1, 32'h0000_0001, "R8 low word from old snapshot");
        rd(3'd2, 32'h0000_0001, "R8 high word from old snapshot");
        rd(3'd0, 32'h0000_00BB, "R8 relatch fraction");
        rd(3'd1, 32'h0000_0002, "R8 low word after relatch");

        // R8: coherent snapshot across a low-word rollover while running
        set_time(40'h00_FFFF_FFF0, 32'h0);
        wr(3'd4, 32'h0);
        repeat (6) @(negedge clk);
        rd(3'd0, 32'h0, "R8 running latch fraction");
        repeat (5) @(negedge clk);
        rd(3'd1, 32'h0000_0020, "R8 running snapshot low");
        repeat (3) @(negedge clk);
        rd(3'd2, 32'h0000_0001, "R8 running snapshot high");
        wr(3'd4, 32'h8000_0000);

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R7 missing read data actual=%0d expected=0 pending", sb.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule